// File: doc/BRIEF.md
# Byte-Lane Load/Store Unit

This block carries out the memory-access step of a small integer core. For each request it adds the base register to the sign-extended immediate to form a byte address. For a store it steers the source data into the right byte lanes and raises the matching byte enables. For a load it takes the addressed lane or lanes from the returned word and widens the value to 32 bits, with sign or zero extension as selected. It connects directly to a 32-bit little-endian synchronous RAM that has per-byte write enables and one cycle of read latency.

The core presents `req_valid_i` for one cycle with the operation class, the width code (funct3), the base value, the decoded immediate and the store data. The unit can take a new request on every cycle. Exactly one cycle after a request, `done_o` pulses. In that cycle the unit also presents the load result, or one of two error flags. An illegal width code is flagged so the core can halt with status 2. A halfword or word access that crosses its natural alignment is flagged as misaligned. Neither kind of faulting request reaches the RAM.

Top module: `lane_lsu`

## Requirements
- R1: `mem_addr_o` equals the low ADDR_W bits of `base_i` plus the sign-extended `imm_i`. It is valid in the same cycle as the request.
- R2: A store with funct3 000 drives a byte enable that is one-hot at bit `addr[1:0]`. The write data holds `store_data_i[7:0]` in all four lanes.
- R3: A store with funct3 001 enables lanes 1:0 when `addr[1]`=0 and lanes 3:2 when `addr[1]`=1. The write data holds `store_data_i[15:0]` in both halves.
- R4: A store with funct3 010 enables all four lanes and writes `store_data_i` unchanged.
- R5: A load with funct3 000 returns the byte at lane `addr[1:0]` sign-extended. Funct3 100 returns the same byte zero-extended.
- R6: A load with funct3 001 returns the halfword at lanes selected by `addr[1]` sign-extended. Funct3 101 returns it zero-extended.
- R7: A load with funct3 010 returns the whole word as read.
- R8: A store funct3 outside {000,001,010}, or a load funct3 outside {000,001,010,100,101}, is illegal. No `mem_req_o` is raised, and `illegal_o` is high with `done_o` one cycle later.
- R9: A legal halfword access with `addr[0]`=1, or a legal word access with `addr[1:0]`≠0, is misaligned. No `mem_req_o` is raised, and `misaligned_o` is high with `done_o` one cycle later. Illegal takes precedence, so the two flags are never high together.
- R10: `done_o` pulses exactly one cycle after each cycle with `req_valid_i` high, including back-to-back requests. It is low otherwise and low after reset.
- R11: `load_data_o` is zero in any cycle that does not complete a successful load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, one cycle per access |
| req_is_store_i | input | 1 | 1 = store, 0 = load |
| funct3_i | input | 3 | Width and extension code |
| base_i | input | 32 | Base register value |
| imm_i | input | IMM_W | Decoded immediate, sign-extended internally |
| store_data_i | input | 32 | Source register value for stores |
| mem_req_o | output | 1 | RAM access strobe |
| mem_we_o | output | 1 | RAM write strobe |
| mem_addr_o | output | ADDR_W | RAM byte address |
| mem_be_o | output | 4 | RAM byte write enables |
| mem_wdata_o | output | 32 | RAM lane-aligned write data |
| mem_rdata_i | input | 32 | RAM read data, one cycle after request |
| done_o | output | 1 | Completion pulse |
| load_data_o | output | 32 | Extended load result |
| illegal_o | output | 1 | Illegal width code flag |
| misaligned_o | output | 1 | Misaligned access flag |

## Verification
The bench builds the unit with ADDR_W=8 and the default 12-bit immediate, so a 64-word RAM model covers the whole address space. The narrow address means a base with high bits set lands inside that space, which exercises the truncation in R1. Negative immediates exercise the sign extension. Stores are issued on consecutive cycles and later read back as words, so lane steering and enables are tested end to end as well as at the RAM pins.

// File: rtl/lane_lsu_pkg.sv
package lane_lsu_pkg;
  localparam int unsigned XLEN  = 32;
  localparam int unsigned LANES = XLEN / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lane_lsu_agen.sv
module lane_lsu_agen
  import lane_lsu_pkg::*;
#(
  parameter int unsigned IMM_W = 12
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             is_store_i,
  input  logic [2:0]       funct3_i,
  output logic [XLEN-1:0]  addr_o,
  output logic             illegal_o,
  output logic             misaligned_o
);
  logic [XLEN-1:0] imm_sx;
  acc_size_e       size;

  assign imm_sx = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign addr_o = base_i + imm_sx;
  assign size   = acc_size_e'(funct3_i[1:0]);

  always_comb begin
    if (is_store_i) illegal_o = funct3_i[2] | (size == SZ_RSVD);
    else            illegal_o = (size == SZ_RSVD) | (funct3_i[2] & size == SZ_WORD);
  end

  // illegal wins over misaligned
  always_comb begin
    misaligned_o = 1'b0;
    if (!illegal_o) begin
      unique case (size)
        SZ_HALF: misaligned_o = addr_o[0];
        SZ_WORD: misaligned_o = |addr_o[1:0];
        default: misaligned_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/lane_lsu_store_align.sv
module lane_lsu_store_align
  import lane_lsu_pkg::*;
(
  input  logic [1:0]      size_i,
  input  logic [1:0]      off_i,
  input  logic [XLEN-1:0] data_i,
  output logic [LANES-1:0] be_o,
  output logic [XLEN-1:0] wdata_o
);
  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    always_comb begin
      unique case (acc_size_e'(size_i))
        SZ_BYTE: begin
          be_o[gl]           = (off_i == gl[1:0]);
          wdata_o[gl*8 +: 8] = data_i[7:0];
        end
        SZ_HALF: begin
          be_o[gl]           = (off_i[1] == gl[1]);
          wdata_o[gl*8 +: 8] = data_i[(gl%2)*8 +: 8];
        end
        default: begin
          be_o[gl]           = 1'b1;
          wdata_o[gl*8 +: 8] = data_i[gl*8 +: 8];
        end
      endcase
    end
  end
endmodule

// File: rtl/lane_lsu_load_extract.sv
module lane_lsu_load_extract
  import lane_lsu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cap_i,
  input  logic            is_store_i,
  input  logic [2:0]      funct3_i,
  input  logic [1:0]      off_i,
  input  logic            illegal_i,
  input  logic            misaligned_i,
  input  logic [XLEN-1:0] rdata_i,
  output logic            done_o,
  output logic [XLEN-1:0] data_o,
  output logic            illegal_o,
  output logic            misaligned_o
);
  logic       vld_q, st_q, ill_q, mis_q;
  logic [2:0] f3_q;
  logic [1:0] off_q;
  logic [XLEN-1:0] shifted;
  logic            ld_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      st_q  <= 1'b0;
      ill_q <= 1'b0;
      mis_q <= 1'b0;
      f3_q  <= '0;
      off_q <= '0;
    end else begin
      vld_q <= cap_i;
      if (cap_i) begin
        st_q  <= is_store_i;
        ill_q <= illegal_i;
        mis_q <= misaligned_i;
        f3_q  <= funct3_i;
        off_q <= off_i;
      end
    end
  end

  assign shifted = rdata_i >> {off_q, 3'b000};
  assign ld_ok   = vld_q & ~st_q & ~ill_q & ~mis_q;

  always_comb begin
    data_o = '0;
    if (ld_ok) begin
      unique case (acc_size_e'(f3_q[1:0]))
        SZ_BYTE: data_o = {{(XLEN-8){shifted[7] & ~f3_q[2]}}, shifted[7:0]};
        SZ_HALF: data_o = {{(XLEN-16){shifted[15] & ~f3_q[2]}}, shifted[15:0]};
        default: data_o = shifted;
      endcase
    end
  end

  assign done_o       = vld_q;
  assign illegal_o    = vld_q & ill_q;
  assign misaligned_o = vld_q & mis_q;
endmodule

// File: rtl/lane_lsu.sv
module lane_lsu
  import lane_lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IMM_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_is_store_i,
  input  logic [2:0]        funct3_i,
  input  logic [31:0]       base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [31:0]       store_data_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              done_o,
  output logic [31:0]       load_data_o,
  output logic              illegal_o,
  output logic              misaligned_o
);
  logic [XLEN-1:0]  eff_addr;
  logic             dec_ill, dec_mis;
  logic [LANES-1:0] st_be;

  lane_lsu_agen #(.IMM_W(IMM_W)) u_agen (
    .base_i      (base_i),
    .imm_i       (imm_i),
    .is_store_i  (req_is_store_i),
    .funct3_i    (funct3_i),
    .addr_o      (eff_addr),
    .illegal_o   (dec_ill),
    .misaligned_o(dec_mis)
  );

  lane_lsu_store_align u_st (
    .size_i (funct3_i[1:0]),
    .off_i  (eff_addr[1:0]),
    .data_i (store_data_i),
    .be_o   (st_be),
    .wdata_o(mem_wdata_o)
  );

  lane_lsu_load_extract u_ld (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_i       (req_valid_i),
    .is_store_i  (req_is_store_i),
    .funct3_i    (funct3_i),
    .off_i       (eff_addr[1:0]),
    .illegal_i   (dec_ill),
    .misaligned_i(dec_mis),
    .rdata_i     (mem_rdata_i),
    .done_o      (done_o),
    .data_o      (load_data_o),
    .illegal_o   (illegal_o),
    .misaligned_o(misaligned_o)
  );

  assign mem_req_o  = req_valid_i & ~dec_ill & ~dec_mis;
  assign mem_we_o   = mem_req_o & req_is_store_i;
  assign mem_addr_o = eff_addr[ADDR_W-1:0];
  assign mem_be_o   = mem_we_o ? st_be : '0;
endmodule

// File: rtl/lane_lsu_chk.sv
module lane_lsu_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_is_store_i,
  input logic [2:0]        funct3_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [3:0]        mem_be_o,
  input logic              done_o,
  input logic [31:0]       load_data_o,
  input logic              illegal_o,
  input logic              misaligned_o
);
  p_done_follows_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> done_o);
  p_no_spurious_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !done_o);
  p_store_wide_code_blocked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_is_store_i && funct3_i[2]) |-> !mem_req_o);
  p_illegal_with_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> done_o);
  p_word_align_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && funct3_i == 3'b010 && mem_addr_o[1:0] != 2'b00) |-> !mem_req_o);
  p_flags_exclusive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(illegal_o && misaligned_o));
  p_byte_be_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && funct3_i == 3'b000) |-> $countones(mem_be_o) == 1);
  p_word_be_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && funct3_i == 3'b010) |-> mem_be_o == 4'hF);
  p_lbu_zero_ext_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_is_store_i && funct3_i == 3'b100) |=> load_data_o[31:8] == 24'h0);
  p_quiet_data_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> load_data_o == 32'h0);
endmodule

bind lane_lsu lane_lsu_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_lane_lsu.sv
module sim_lane_lsu;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 8;
  localparam logic [31:0] SDATA = 32'hA1B2C3D4;

  typedef struct packed {
    logic        st;
    logic [2:0]  f3;
    logic [31:0] base;
    logic [11:0] imm;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [7:0]  addr;
    logic [31:0] ld;
    logic [1:0]  err; // 0 ok, 1 illegal, 2 misaligned
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 3'b000, 32'h20, 12'h001, 4'b0010, 32'hD4D4D4D4, 8'h21, 32'h0, 2'd0},
    '{1'b1, 3'b000, 32'h20, 12'h003, 4'b1000, 32'hD4D4D4D4, 8'h23, 32'h0, 2'd0},
    '{1'b1, 3'b001, 32'h20, 12'h002, 4'b1100, 32'hC3D4C3D4, 8'h22, 32'h0, 2'd0},
    '{1'b1, 3'b001, 32'h20, 12'h000, 4'b0011, 32'hC3D4C3D4, 8'h20, 32'h0, 2'd0},
    '{1'b1, 3'b010, 32'h30, 12'hFF4, 4'b1111, 32'hA1B2C3D4, 8'h24, 32'h0, 2'd0},
    '{1'b0, 3'b000, 32'h10, 12'hFF4, 4'b0000, 32'h0, 8'h04, 32'hFFFFFF82, 2'd0},
    '{1'b0, 3'b100, 32'h10, 12'hFF4, 4'b0000, 32'h0, 8'h04, 32'h00000082, 2'd0},
    '{1'b0, 3'b000, 32'h04, 12'h001, 4'b0000, 32'h0, 8'h05, 32'h0000007F, 2'd0},
    '{1'b0, 3'b000, 32'h04, 12'h003, 4'b0000, 32'h0, 8'h07, 32'hFFFFFF80, 2'd0},
    '{1'b0, 3'b100, 32'h04, 12'h002, 4'b0000, 32'h0, 8'h06, 32'h000000F1, 2'd0},
    '{1'b0, 3'b001, 32'h04, 12'h000, 4'b0000, 32'h0, 8'h04, 32'h00007F82, 2'd0},
    '{1'b0, 3'b001, 32'h04, 12'h002, 4'b0000, 32'h0, 8'h06, 32'hFFFF80F1, 2'd0},
    '{1'b0, 3'b101, 32'h04, 12'h002, 4'b0000, 32'h0, 8'h06, 32'h000080F1, 2'd0},
    '{1'b0, 3'b010, 32'h04, 12'h000, 4'b0000, 32'h0, 8'h04, 32'h80F17F82, 2'd0},
    '{1'b0, 3'b010, 32'h10000000, 12'h020, 4'b0000, 32'h0, 8'h20, 32'hC3D4C3D4, 2'd0},
    '{1'b0, 3'b010, 32'h24, 12'h000, 4'b0000, 32'h0, 8'h24, 32'hA1B2C3D4, 2'd0},
    '{1'b1, 3'b011, 32'h20, 12'h000, 4'b0000, 32'h0, 8'h20, 32'h0, 2'd1},
    '{1'b1, 3'b101, 32'h20, 12'h000, 4'b0000, 32'h0, 8'h20, 32'h0, 2'd1},
    '{1'b0, 3'b110, 32'h20, 12'h000, 4'b0000, 32'h0, 8'h20, 32'h0, 2'd1},
    '{1'b0, 3'b111, 32'h21, 12'h000, 4'b0000, 32'h0, 8'h21, 32'h0, 2'd1},
    '{1'b0, 3'b001, 32'h05, 12'h000, 4'b0000, 32'h0, 8'h05, 32'h0, 2'd2},
    '{1'b0, 3'b010, 32'h06, 12'h000, 4'b0000, 32'h0, 8'h06, 32'h0, 2'd2},
    '{1'b1, 3'b001, 32'h21, 12'h000, 4'b0000, 32'h0, 8'h21, 32'h0, 2'd2},
    '{1'b0, 3'b101, 32'h04, 12'h001, 4'b0000, 32'h0, 8'h05, 32'h0, 2'd2},
    '{1'b1, 3'b010, 32'h22, 12'h000, 4'b0000, 32'h0, 8'h22, 32'h0, 2'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_st = 1'b0;
  logic [2:0] f3 = '0;
  logic [31:0] base = '0, sdata = '0;
  logic [11:0] imm = '0;
  logic mem_req, mem_we, done, ill, mis;
  logic [ADDR_W-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata, ld_data;
  logic [31:0] ram [64];
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  lane_lsu #(.ADDR_W(ADDR_W), .IMM_W(12)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_is_store_i(req_st),
    .funct3_i(f3), .base_i(base), .imm_i(imm), .store_data_i(sdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .done_o(done),
    .load_data_o(ld_data), .illegal_o(ill), .misaligned_o(mis)
  );

  // RAM model: byte-enabled writes, one-cycle read latency
  initial begin
    for (int w = 0; w < 64; w++) ram[w] = 32'h0;
    ram[1] = 32'h80F17F82;
    mem_rdata = '0;
  end
  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) ram[mem_addr[7:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    end else if (mem_req) begin
      mem_rdata <= ram[mem_addr[7:2]];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(vec_t v);
    if (v.err == 2'd1) return "R8";
    if (v.err == 2'd2) return "R9";
    if (v.st) return (v.f3 == 3'b000) ? "R2" : (v.f3 == 3'b001) ? "R3" : "R4";
    return (v.f3[1:0] == 2'b00) ? "R5" : (v.f3[1:0] == 2'b01) ? "R6" : "R7";
  endfunction

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P*2 + 1);
    chk("R10 reset done", {31'b0, done}, 32'h0);
    chk("R11 reset data", ld_data, 32'h0);
    chk("R8 reset flags", {30'b0, ill, mis}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string t;
      v = TBL[i];
      t = tag_of(v);
      req_valid = 1'b1; req_st = v.st; f3 = v.f3; base = v.base; imm = v.imm; sdata = SDATA;
      #1;
      chk({t, " mem_req"}, {31'b0, mem_req}, {31'b0, v.err == 2'd0});
      if (v.err == 2'd0) begin
        chk("R1 addr", {24'b0, mem_addr}, {24'b0, v.addr});
        chk({t, " we"}, {31'b0, mem_we}, {31'b0, v.st});
        if (v.st) begin
          chk({t, " be"}, {28'b0, mem_be}, {28'b0, v.be});
          chk({t, " wdata"}, mem_wdata, v.wd);
        end
      end
      @(negedge clk);
      chk("R10 done", {31'b0, done}, 32'h1);
      chk({t, " illegal"}, {31'b0, ill}, {31'b0, v.err == 2'd1});
      chk({t, " misaligned"}, {31'b0, mis}, {31'b0, v.err == 2'd2});
      chk((v.st || v.err != 2'd0) ? "R11 data" : {t, " data"}, ld_data, v.ld);
    end

    req_valid = 1'b0;
    #1;
    chk("R10 idle mem_req", {31'b0, mem_req}, 32'h0);
    @(negedge clk);
    chk("R10 idle done", {31'b0, done}, 32'h0);
    chk("R11 idle data", ld_data, 32'h0);

    // reset while a load is in flight
    req_valid = 1'b1; req_st = 1'b0; f3 = 3'b010; base = 32'h4; imm = '0;
    #1 rst_n = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 reset drops done", {31'b0, done}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after reset", {31'b0, done}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule